// File: doc/BRIEF.md
# SPI Frame Queues with Watermark Interrupt

This block sits between a register port and the serial shifting engine of an SPI controller. Software writes outgoing frames into a transmit queue and reads incoming frames from a receive queue. The serial engine takes frames from the transmit side and delivers frames to the receive side through a simple pop/push port. Serial timing is handled outside this block.

Each queue holds `DEPTH` frames of `FRAME_W` bits. The default is 8 frames of 8 bits. The queue status sits in the top bit of each data register. Reading the receive data register pops a frame only when one is present.

Two watermark conditions are derived from programmable marks. One fires when the transmit queue is running low, the other when the receive queue has filled past its mark. Each condition is gated by an enable bit, and the gated conditions are ORed into a single interrupt line.

Register port reads are combinational. Writes, pops and pushes take effect on the rising clock edge.

Register index map on `reg_addr`:

| Index | Register |
|-------|----------|
| 0 | transmit data |
| 1 | receive data |
| 2 | transmit mark |
| 3 | receive mark |
| 4 | interrupt enable |
| 5 | interrupt pending |

Top module: `spi_fifo_regs`

## Requirements
- R1: After reset, the registers read as follows, `irq` is 0, `eng_tx_valid` is 0 and `eng_rx_ready` is 1.
  - transmit mark reads 1
  - receive mark reads 0
  - enable reads 0
  - transmit data reads 0 (not full)
  - receive data reads 0x80000000 (empty)
- R2: A write to index 0 while the transmit queue is not full enqueues `reg_wdata[7:0]`. The engine sees frames on `eng_tx_data` in write order while `eng_tx_valid` is 1, and each `eng_tx_pop` removes one.
- R3: A read of index 0 returns bit 31 set exactly when the transmit queue holds `DEPTH` frames. A write to index 0 while full is dropped, and the queued frames are unchanged.
- R4: A read of index 1 while the receive queue is not empty returns the oldest frame in bits 7:0 with bit 31 clear, and removes that frame.
- R5: A read of index 1 while the receive queue is empty returns 0x80000000 and changes no queue state. A later push is then read back first.
- R6: Pending bit 0 (index 5) is 1 exactly while the transmit queue count is strictly less than the transmit mark.
- R7: Pending bit 1 (index 5) is 1 exactly while the receive queue count is strictly greater than the receive mark.
- R8: `irq` is the OR of the pending bits ANDed with the enable bits. Writing index 5 has no effect on the pending bits.
- R9: `eng_rx_ready` is 0 while the receive queue is full. An `eng_rx_push` while full is dropped.
- R10: The marks (index 2, 3) hold `$clog2(DEPTH+1)` bits and read back what was written. The enable register (index 4) holds bits 1:0: bit 0 for transmit, bit 1 for receive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| eng_tx_valid | output | 1 | Transmit queue holds a frame |
| eng_tx_data | output | FRAME_W | Oldest transmit frame |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit frame |
| eng_rx_push | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | FRAME_W | Received frame |
| eng_rx_ready | output | 1 | Receive queue can accept a frame |
| irq | output | 1 | Combined watermark interrupt |

## Verification
A corrupted pointer or count shows up at the ports within one access. It appears as a wrong frame on `eng_tx_data` or in a receive read, or as a wrong full or empty flag in bit 31. It also appears as a pending bit that disagrees with the count implied by the pushes and pops issued so far.

A pop taken on an empty receive queue would only surface on the next real frame, which would arrive out of order. The stimulus therefore always follows an empty read with a push and a read-back.

Dropped writes and pushes at full are checked by draining the queue and comparing every frame.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [2:0] {
    RIX_TXD = 3'd0,
    RIX_RXD = 3'd1,
    RIX_TXM = 3'd2,
    RIX_RXM = 3'd3,
    RIX_IE  = 3'd4,
    RIX_IP  = 3'd5
  } reg_ix_t;

  localparam int REG_W    = 32;
  localparam int FLAG_BIT = 31;
  localparam int PEND_TX  = 0;
  localparam int PEND_RX  = 1;

  // transmit side wants service while it runs below its mark
  function automatic logic tx_low(input int unsigned cnt, input int unsigned mark);
    return cnt < mark;
  endfunction

  // receive side wants service once it rises above its mark
  function automatic logic rx_high(input int unsigned cnt, input int unsigned mark);
    return cnt > mark;
  endfunction

  // next pointer value with wrap at an arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/spi_frame_queue.sv
module spi_frame_queue #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  import spi_fifo_pkg::*;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = store[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(ptr_next(32'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(ptr_next(32'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store[i] <= '0;
      else if (push_ok && wr_ptr == PTR_W'(i)) store[i] <= push_data;
    end
  end

endmodule

// File: rtl/spi_wm_irq.sv
module spi_wm_irq #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_mark,
  input  logic [CNT_W-1:0] rx_mark,
  input  logic [1:0]       irq_en,
  output logic [1:0]       pend,
  output logic             irq
);
  import spi_fifo_pkg::*;

  always_comb begin
    pend          = '0;
    pend[PEND_TX] = tx_low(32'(tx_count), 32'(tx_mark));
    pend[PEND_RX] = rx_high(32'(rx_count), 32'(rx_mark));
  end

  assign irq = |(pend & irq_en);

endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs #(
  parameter int DEPTH   = 8,
  parameter int FRAME_W = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               eng_tx_valid,
  output logic [FRAME_W-1:0] eng_tx_data,
  input  logic               eng_tx_pop,
  input  logic               eng_rx_push,
  input  logic [FRAME_W-1:0] eng_rx_data,
  output logic               eng_rx_ready,
  output logic               irq
);
  import spi_fifo_pkg::*;

  // named internal events, used by the bound checker
  logic               tx_wr_req, rx_rd_req;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0]   tx_count, rx_count;
  logic [CNT_W-1:0]   tx_mark, rx_mark;
  logic [1:0]         irq_en, pend;
  logic [FRAME_W-1:0] rx_head;
  logic               unused_wdata;

  assign tx_wr_req    = reg_wr && (reg_addr == RIX_TXD);
  assign rx_rd_req    = reg_rd && (reg_addr == RIX_RXD);
  assign unused_wdata = ^reg_wdata;

  spi_frame_queue #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr_req), .push_data(reg_wdata[FRAME_W-1:0]),
    .pop(eng_tx_pop), .head(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  spi_frame_queue #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rx_rd_req), .head(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_ready = !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_mark <= CNT_W'(1);
      rx_mark <= '0;
      irq_en  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RIX_TXM: tx_mark <= reg_wdata[CNT_W-1:0];
        RIX_RXM: rx_mark <= reg_wdata[CNT_W-1:0];
        RIX_IE:  irq_en  <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  spi_wm_irq #(.CNT_W(CNT_W)) u_wm (
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_mark(tx_mark), .rx_mark(rx_mark),
    .irq_en(irq_en), .pend(pend), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RIX_TXD: reg_rdata[FLAG_BIT] = tx_full;
      RIX_RXD: begin
        if (rx_empty) reg_rdata[FLAG_BIT] = 1'b1;
        else          reg_rdata[FRAME_W-1:0] = rx_head;
      end
      RIX_TXM: reg_rdata[CNT_W-1:0] = tx_mark;
      RIX_RXM: reg_rdata[CNT_W-1:0] = rx_mark;
      RIX_IE:  reg_rdata[1:0] = irq_en;
      RIX_IP:  reg_rdata[1:0] = pend;
      default: ;
    endcase
  end

endmodule

// File: rtl/spi_fifo_regs_chk.sv
module spi_fifo_regs_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_wr_req,
  input logic             rx_rd_req,
  input logic             eng_tx_pop,
  input logic             eng_rx_push,
  input logic             eng_rx_ready,
  input logic             irq,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_mark,
  input logic [CNT_W-1:0] rx_mark,
  input logic [1:0]       irq_en
);

  p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_req && tx_count == CNT_W'(DEPTH) && !eng_tx_pop) |=> $stable(tx_count));

  p_rx_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_req && rx_count != '0 && !eng_rx_push) |=> (rx_count == $past(rx_count) - 1'b1));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_req && rx_count == '0 && !eng_rx_push) |=> (rx_count == '0));

  p_txwm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[0] && tx_count < tx_mark) |-> irq);

  p_rxwm_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[1] && rx_count > rx_mark) |-> irq);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irq_en[0] && tx_count < tx_mark) || (irq_en[1] && rx_count > rx_mark)));

  p_rx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CNT_W'(DEPTH)) |-> !eng_rx_ready);

endmodule

bind spi_fifo_regs spi_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_wr_req(tx_wr_req), .rx_rd_req(rx_rd_req),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
  .eng_rx_ready(eng_rx_ready), .irq(irq),
  .tx_count(tx_count), .rx_count(rx_count),
  .tx_mark(tx_mark), .rx_mark(rx_mark), .irq_en(irq_en)
);

// File: tb/spi_fifo_regs_tb.sv
`timescale 1ns/1ps
module spi_fifo_regs_tb;

  localparam int DEPTH = 8;
  localparam int FW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          eng_tx_valid, eng_tx_pop = 1'b0;
  logic [FW-1:0] eng_tx_data;
  logic          eng_rx_push = 1'b0, eng_rx_ready;
  logic [FW-1:0] eng_rx_data = '0;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_regs #(.DEPTH(DEPTH), .FRAME_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
    .irq(irq)
  );

  // register indices
  localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_TXM = 3'd2, A_RXM = 3'd3,
                         A_IE = 3'd4, A_IP = 3'd5;
  // table ops
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PUSH = 2'd2, OP_POP = 2'd3;

  // {op, req, addr, data, expect}
  localparam int NV = 18;
  localparam logic [72:0] VEC [NV] = '{
    {OP_WR,   4'd2,  A_TXD, 32'hA5, 32'h0},         // R2 enqueue
    {OP_RD,   4'd6,  A_IP,  32'h0,  32'h0},         // R6 count 1 == mark 1
    {OP_WR,   4'd2,  A_TXD, 32'h13C,32'h0},         // R2 upper bits ignored
    {OP_RD,   4'd3,  A_TXD, 32'h0,  32'h0},         // R3 not full
    {OP_POP,  4'd2,  A_TXD, 32'h0,  32'hA5},        // R2 order
    {OP_POP,  4'd2,  A_TXD, 32'h0,  32'h3C},
    {OP_RD,   4'd6,  A_IP,  32'h0,  32'h1},         // R6 count 0 < 1
    {OP_PUSH, 4'd9,  A_TXD, 32'h11, 32'h0},
    {OP_RD,   4'd7,  A_IP,  32'h0,  32'h3},         // R7 1 > 0
    {OP_WR,   4'd10, A_RXM, 32'h1,  32'h0},
    {OP_RD,   4'd10, A_RXM, 32'h0,  32'h1},         // R10 readback
    {OP_RD,   4'd7,  A_IP,  32'h0,  32'h1},         // R7 1 == mark 1
    {OP_PUSH, 4'd9,  A_TXD, 32'h22, 32'h0},
    {OP_RD,   4'd7,  A_IP,  32'h0,  32'h3},
    {OP_RD,   4'd4,  A_RXD, 32'h0,  32'h11},        // R4 pop oldest
    {OP_RD,   4'd4,  A_RXD, 32'h0,  32'h22},
    {OP_RD,   4'd5,  A_RXD, 32'h0,  32'h8000_0000}, // R5 empty
    {OP_WR,   4'd10, A_RXM, 32'h0,  32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [FW-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic pop(output logic [FW-1:0] d, output logic v);
    @(negedge clk);
    #1 d = eng_tx_data; v = eng_tx_valid;
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [FW-1:0] f;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, eng_tx_valid}, 32'h0);
    check("R1 rx_ready", {31'b0, eng_rx_ready}, 32'h1);
    rd(A_TXM, r); check("R1 txmark", r, 32'h1);
    rd(A_RXM, r); check("R1 rxmark", r, 32'h0);
    rd(A_IE,  r); check("R1 enable", r, 32'h0);
    rd(A_TXD, r); check("R1 txdata", r, 32'h0);
    rd(A_RXD, r); check("R1 rxdata", r, 32'h8000_0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [2:0]  a;
      logic [31:0] d, e;
      string tag;
      {op, rq, a, d, e} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        OP_WR:   wr(a, d);
        OP_RD:   begin rd(a, r); check(tag, r, e); end
        OP_PUSH: push(d[FW-1:0]);
        default: begin
          pop(f, v);
          check(tag, {23'b0, v, f}, {23'b0, 1'b1, e[FW-1:0]});
        end
      endcase
    end

    // R3 fill transmit queue, overflow write dropped
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'h40 + i);
    rd(A_TXD, r); check("R3 full flag", r, 32'h8000_0000);
    wr(A_TXD, 32'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      pop(f, v);
      check("R3 drain order", {23'b0, v, f}, {23'b0, 1'b1, 8'(8'h40 + i)});
    end
    #1 check("R2 empty after drain", {31'b0, eng_tx_valid}, 32'h0);

    // R9 fill receive queue, overflow push dropped
    for (int i = 0; i < DEPTH; i++) push(8'h50 + 8'(i));
    #1 check("R9 ready low", {31'b0, eng_rx_ready}, 32'h0);
    push(8'h99);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, r); check("R9 drain order", r, 32'h50 + i);
    end

    // R5 empty reads leave pointers alone
    rd(A_RXD, r); check("R5 empty 1", r, 32'h8000_0000);
    rd(A_RXD, r); check("R5 empty 2", r, 32'h8000_0000);
    push(8'h77);
    rd(A_RXD, r); check("R5 next frame", r, 32'h77);

    // R8 interrupt gating
    wr(A_IE, 32'h1);
    #1 check("R8 tx enabled", {31'b0, irq}, 32'h1);
    wr(A_IE, 32'h2);
    #1 check("R8 rx enabled idle", {31'b0, irq}, 32'h0);
    wr(A_IP, 32'h0);
    rd(A_IP, r); check("R8 pending write ignored", r, 32'h1);
    push(8'h01);
    #1 check("R8 rx enabled active", {31'b0, irq}, 32'h1);
    rd(A_RXD, r); check("R4 single", r, 32'h01);
    #1 check("R8 rx cleared", {31'b0, irq}, 32'h0);

    // R10 readback widths
    wr(A_IE, 32'h7);
    rd(A_IE, r); check("R10 enable width", r, 32'h3);
    wr(A_TXM, 32'hF);
    rd(A_TXM, r); check("R10 txmark width", r, 32'hF);

    // R6 boundary with a larger mark
    wr(A_TXM, 32'h3);
    for (int i = 0; i < 2; i++) wr(A_TXD, 32'h10 + i);
    rd(A_IP, r); check("R6 2 < 3", r, 32'h1);
    wr(A_TXD, 32'h12);
    rd(A_IP, r); check("R6 3 == 3", r, 32'h0);
    wr(A_IE, 32'h0);
    #1 check("R8 disabled", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule